// File: doc/BRIEF.md
# Reset Control Port Register

This block is a one-byte register that sits at a single address in I/O space and lets software reset the whole system. When a write to that address has the trigger bit set, the block raises a system reset request. The request lasts for one clock, and the write leaves the stored byte untouched.

Any other write to the address keeps only two configuration bits of the written byte and clears the rest. Software can read those two bits back at the same address. The block only raises the request and keeps the two bits. Sequencing the actual system reset is the job of logic downstream.

The block is clocked and uses a synchronous, active-high reset. Accesses arrive as single-cycle write or read strobes with an address and an 8-bit data bus. Read data is combinational and is valid in the cycle of the read strobe.

Top module: `rstport_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the stored byte clears to 0x00 and `sysrst_req` is low in the following cycle.
- R2: A write to `PORT_ADDR` with bit 2 of `io_wdata` set drives `sysrst_req` high for exactly the one clock after the edge that samples the write. `sysrst_req` is high at no other time.
- R3: A write to `PORT_ADDR` with bit 2 set leaves the stored byte unchanged.
- R4: A write to `PORT_ADDR` with bit 2 clear stores `io_wdata & 0x0A`. Only bits 1 and 3 are kept, and all other stored bits become zero.
- R5: A read at `PORT_ADDR` returns the stored byte on `io_rdata` in the same cycle. When no read hits the port, `io_rdata` is 0x00.
- R6: A write to any address other than `PORT_ADDR` changes nothing: the stored byte keeps its value and `sysrst_req` stays low.
- R7: A write presented while `rst` is high is ignored. The byte still reads 0x00 afterwards, and no request is raised even when bit 2 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | I/O access address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data; 0x00 when no read hits the port |
| sysrst_req | output | 1 | One-clock system reset request |

## Verification
A wrong stored byte shows on the very next read at the port. This happens when a reserved bit leaks in, when a trigger write overwrites the byte, or when a write to another address lands in it. For this reason the bench reads the port back after every write. A request that is missing, late, doubled or spurious shows on `sysrst_req` within one clock of the write that caused it. The bench samples that output in the cycle after each write and again in the cycle after that.

// File: rtl/rstport_pkg.sv
package rstport_pkg;

    localparam int DATA_W      = 8;
    localparam int TRIGGER_BIT = 2;
    localparam logic [DATA_W-1:0] KEEP_MASK = 8'h0A;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_RESET = 2'd2
    } acc_op_e;

    typedef struct packed {
        acc_op_e             op;
        logic [DATA_W-1:0]   data;
    } acc_req_t;

    // Turn one write access into an operation; data is pre-masked for storing.
    function automatic acc_req_t classify_write(input logic wr, input logic hit,
                                                input logic [DATA_W-1:0] wdata);
        acc_req_t r;
        r.op   = ACC_IDLE;
        r.data = '0;
        if (wr && hit) begin
            if (wdata[TRIGGER_BIT]) begin
                r.op = ACC_RESET;
            end else begin
                r.op   = ACC_STORE;
                r.data = wdata & KEEP_MASK;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/rstport_decode.sv
module rstport_decode
    import rstport_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0CF9
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DATA_W-1:0] io_wdata,
    output acc_req_t          acc_o,
    output logic              rd_hit_o
);

    logic hit;

    assign hit      = (io_addr == PORT_ADDR);
    assign rd_hit_o = io_rd && hit;

    always_comb begin
        acc_o = classify_write(io_wr, hit, io_wdata);
    end

endmodule

// File: rtl/rstport_store.sv
module rstport_store
    import rstport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  acc_req_t          acc_i,
    output logic [DATA_W-1:0] held_o
);

    logic [DATA_W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (acc_i.op == ACC_STORE) begin
            held_q <= acc_i.data;
        end
    end

    assign held_o = held_q;

endmodule

// File: rtl/rstport_pulse.sv
module rstport_pulse
    import rstport_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  acc_req_t acc_i,
    output logic     req_o
);

    logic req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
        end else begin
            req_q <= (acc_i.op == ACC_RESET);
        end
    end

    assign req_o = req_q;

endmodule

// File: rtl/rstport_ctrl.sv
module rstport_ctrl
    import rstport_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0CF9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              sysrst_req
);

    acc_req_t          acc;
    logic              rd_hit;
    logic [DATA_W-1:0] held_q;

    rstport_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) dec_i (
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_wdata (io_wdata),
        .acc_o    (acc),
        .rd_hit_o (rd_hit)
    );

    rstport_store store_i (
        .clk    (clk),
        .rst    (rst),
        .acc_i  (acc),
        .held_o (held_q)
    );

    rstport_pulse pulse_i (
        .clk   (clk),
        .rst   (rst),
        .acc_i (acc),
        .req_o (sysrst_req)
    );

    assign io_rdata = rd_hit ? held_q : '0;

endmodule

// File: rtl/rstport_ctrl_chk.sv
module rstport_ctrl_chk #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0CF9
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              sysrst_req,
    input logic [7:0]        held_val
);

    logic hit;
    logic trig;
    assign hit  = (io_addr == PORT_ADDR);
    assign trig = io_wr && hit && io_wdata[2];

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (held_val == 8'h00 && !sysrst_req));

    // R2
    a_r2_req_follows_trigger: assert property (@(posedge clk) disable iff (rst)
        trig |=> sysrst_req);

    // R2
    a_r2_req_only_after_trigger: assert property (@(posedge clk) disable iff (rst)
        sysrst_req |-> $past(trig));

    // R3
    a_r3_trigger_keeps_value: assert property (@(posedge clk) disable iff (rst)
        trig |=> $stable(held_val));

    // R4
    a_r4_masked_store: assert property (@(posedge clk) disable iff (rst)
        (io_wr && hit && !io_wdata[2]) |=> (held_val == ($past(io_wdata) & 8'h0A)));

    // R5
    a_r5_read_returns_value: assert property (@(posedge clk) disable iff (rst)
        (io_rd && hit) |-> (io_rdata == held_val));

    // R5
    a_r5_idle_read_zero: assert property (@(posedge clk) disable iff (rst)
        !(io_rd && hit) |-> (io_rdata == 8'h00));

    // R6
    a_r6_miss_no_effect: assert property (@(posedge clk) disable iff (rst)
        (io_wr && !hit) |=> ($stable(held_val) && !sysrst_req));

endmodule

bind rstport_ctrl rstport_ctrl_chk #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .io_addr    (io_addr),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .sysrst_req (sysrst_req),
    .held_val   (held_q)
);

// File: tb/rstport_ctrl_tb_top.sv
`timescale 1ns/1ps
module rstport_ctrl_tb_top;

    localparam int          ADDR_W = 16;
    localparam logic [15:0] PORT   = 16'h0CF9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        sysrst_req;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] model = 8'h00;

    always #10 clk = ~clk;

    rstport_ctrl #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT)) dut_i (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .sysrst_req(sysrst_req)
    );

    function automatic logic [7:0] expect_store(input logic [7:0] d);
        return d & 8'h0A;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic read_check(input string req);
        @(negedge clk);
        io_addr = PORT;
        io_rd   = 1'b1;
        #1;
        check(req, io_rdata, model);
        io_rd = 1'b0;
        #1;
        check("R5 idle read zero", io_rdata, 8'h00);
    endtask

    // One write, then check the request pulse in the two cycles after it.
    task automatic do_write(input logic [15:0] a, input logic [7:0] d, input string req);
        logic hit;
        logic fire;
        hit  = (a == PORT);
        fire = hit && d[2] && !rst;
        @(negedge clk);
        io_addr  = a;
        io_wdata = d;
        io_wr    = 1'b1;
        @(posedge clk);
        #2;
        check({req, " req pulse"}, {7'b0, sysrst_req}, {7'b0, fire});
        @(negedge clk);
        io_wr = 1'b0;
        @(posedge clk);
        #2;
        check("R2 req one clock", {7'b0, sysrst_req}, 8'h00);
        if (rst) model = 8'h00;
        else if (hit && !d[2]) model = expect_store(d);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        check("R1 req in reset", {7'b0, sysrst_req}, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        read_check("R1 reset value");

        // R4 directed
        do_write(PORT, 8'hFF & ~8'h04, "R4");
        read_check("R4 mask 0xFB");
        do_write(PORT, 8'hF5, "R4");
        read_check("R4 mask 0xF5");
        do_write(PORT, 8'h0A, "R4");
        read_check("R4 keep 0x0A");

        // R3 trigger keeps stored value, R2 pulse
        do_write(PORT, 8'h04, "R2");
        read_check("R3 trigger keeps value");
        do_write(PORT, 8'hFF, "R2");
        read_check("R3 trigger 0xFF keeps value");

        // R6 other addresses
        do_write(PORT + 16'd1, 8'h00, "R6");
        read_check("R6 miss no store");
        do_write(16'h0000, 8'h04, "R6");
        read_check("R6 miss no request");

        // Back-to-back trigger writes give one pulse each
        @(negedge clk);
        io_addr = PORT; io_wdata = 8'h06; io_wr = 1'b1;
        @(posedge clk); #2;
        check("R2 first of pair", {7'b0, sysrst_req}, 8'h01);
        @(posedge clk); #2;
        check("R2 second of pair", {7'b0, sysrst_req}, 8'h01);
        @(negedge clk); io_wr = 1'b0;
        @(posedge clk); #2;
        check("R2 pair ends", {7'b0, sysrst_req}, 8'h00);
        read_check("R3 pair keeps value");

        // R7 writes during reset
        @(negedge clk); rst = 1'b1;
        do_write(PORT, 8'h0A, "R7");
        do_write(PORT, 8'h04, "R7");
        @(negedge clk); rst = 1'b0;
        read_check("R7 reset write ignored");

        // Random mix
        for (int i = 0; i < 300; i++) begin
            logic [15:0] a;
            logic [7:0]  d;
            a = ($urandom % 2) ? PORT : 16'($urandom);
            d = 8'($urandom);
            do_write(a, d, (a == PORT) ? (d[2] ? "R2" : "R4") : "R6");
            read_check(d[2] ? "R3 random" : "R4 random");
        end

        finish_run();
    end

endmodule